// File: doc/BRIEF.md
# Accelerator Task Trigger Controller

This block decides when each of eight accelerator tasks is started. Every task picks one of the peripheral request lines through its own source-select register. A line requests service on a high-to-low transition only, so a level that is already low when a task is armed never starts it. Tasks can also be started from software through an acknowledge-start command, which is gated by a control bit. The block keeps the enable, pending-flag, running and per-task overflow state. It hands one task at a time to an execution engine. It returns a completion pulse for each finished task and an overflow pulse to the host interrupt controller.

The highest slot can instead act as a background task. In that mode the software acknowledge is ignored for that slot, and the slot is started by a dedicated start write. Peripheral edges on its source count only when a trigger-gate bit is set. A trigger that arrives while the background task is already busy sets a sticky overflow bit. An underflow report from the engine is passed on as its own interrupt pulse.

Top module: `task_launch_ctrl`

## Requirements
- R1: A high-to-low transition on the line chosen for task t (select value k in 1..8 picks line k-1) sets flag bit t one cycle after the clock edge that samples the low level, when enable bit t is 1. A steady level sets nothing.
- R2: A transition that happens while enable bit t is 0 is dropped. Setting the enable later, while the line stays low, does not set the flag.
- R3: A select value of 0 ties the task to no line, so no line transition sets its flag. Two tasks that select the same line are flagged by the same transition.
- R4: A software acknowledge (ackValid with ackTask=t) sets flag t only while control bit 0 (acknowledge enable, config address 2) is 1 and enable bit t is 1.
- R5: When no task is running and flags are pending, the lowest-numbered flagged task is launched. launchValid pulses for one cycle with launchTask, that flag clears and its run bit sets on the same cycle. At most one run bit is ever set.
- R6: doneValid with doneTask naming the running task clears its run bit and pulses the matching doneIrq bit one cycle later. doneValid for a task that is not running is ignored.
- R7: A trigger for a task whose flag is already set sets overflow bit t and pulses ovfIrq one cycle later. Writing a 1 to bit t at config address 1 clears it, and a new overflow on the same cycle takes priority over the clear.
- R8: With control bit 1 (background mode, address 2) set, task 7 ignores software acknowledges. It is started by writing bit 0 = 1 to address 3, provided enable bit 7 is 1.
- R9: In background mode, line transitions for task 7 count only while control bit 2 (trigger gate) is 1. A trigger while task 7 is running or pending sets bgOvf and pulses ovfIrq instead of a flag. Writing bit 0 = 1 to address 4 clears bgOvf.
- R10: An engUnderflow pulse appears on undIrq one cycle later.
- R11: After reset all flags, run bits, overflow bits and interrupt outputs are 0. Source selects are 0, the enable register is 0, and all control bits are 0. Writing address 0 loads the enable register, and writing address 8+t loads the source select of task t.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| srcLines | input | 8 | Peripheral request lines, active on falling edge |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | 4 | Configuration register address |
| cfgWdata | input | 8 | Configuration write data |
| ackValid | input | 1 | Software acknowledge-start command |
| ackTask | input | 3 | Task addressed by the acknowledge |
| doneValid | input | 1 | Engine reports task completion |
| doneTask | input | 3 | Task that completed |
| engUnderflow | input | 1 | Engine underflow report |
| launchValid | output | 1 | One-cycle launch strobe to the engine |
| launchTask | output | 3 | Task being launched |
| runMask | output | 8 | Running-task status |
| flagMask | output | 8 | Pending-task flags |
| ovfMask | output | 8 | Sticky per-task overflow bits |
| bgOvf | output | 1 | Sticky background-task overflow |
| doneIrq | output | 8 | Per-task completion interrupt pulses |
| ovfIrq | output | 1 | Overflow interrupt pulse |
| undIrq | output | 1 | Underflow interrupt pulse |

## Verification
A line drop or acknowledge sampled at rising edge N is reflected in flagMask, in ovfMask and in ovfIrq after edge N. The launch of a pending task follows one edge after its flag becomes visible. Completion clears run and raises doneIrq one edge after doneValid, and undIrq trails engUnderflow by one edge. The bench advances a behavioural model on each rising edge from the same inputs and compares every output at the following falling edge, so each result is checked in exactly the cycle it is due. A few scenario checks with fixed values confirm that ignored stimuli leave the run and flag state empty.

// File: rtl/tlc_pkg.sv
package tlc_pkg;
  localparam int TLC_TASKS    = 8;
  localparam int TLC_IDX_W    = $clog2(TLC_TASKS);
  localparam int A_ENABLE     = 0;
  localparam int A_OVF_CLR    = 1;
  localparam int A_CTRL       = 2;
  localparam int A_BG_START   = 3;
  localparam int A_BG_OVF_CLR = 4;
  localparam int A_SEL_BASE   = 8;
  localparam int TLC_ADDR_W   = $clog2(A_SEL_BASE + TLC_TASKS);

  typedef struct packed {
    logic [TLC_TASKS-1:0] setFlag;
    logic [TLC_TASKS-1:0] setOvf;
    logic                 setBgOvf;
    logic                 launch;
    logic [TLC_IDX_W-1:0] launchIdx;
    logic [TLC_TASKS-1:0] finish;
  } strobe_t;
endpackage

// File: rtl/tlc_trigger_ctl.sv
module tlc_trigger_ctl
  import tlc_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int SEL_W   = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_SRC-1:0]         srcLines,
  input  logic [TLC_TASKS*SEL_W-1:0] selFlat,
  input  logic [TLC_TASKS-1:0]       enableMask,
  input  logic [TLC_TASKS-1:0]       flagMask,
  input  logic [TLC_TASKS-1:0]       runMask,
  input  logic                       ackEnable,
  input  logic                       bgEnable,
  input  logic                       bgTrigEn,
  input  logic                       bgStartWr,
  input  logic                       ackValid,
  input  logic [TLC_IDX_W-1:0]       ackTask,
  input  logic                       doneValid,
  input  logic [TLC_IDX_W-1:0]       doneTask,
  output strobe_t                    stb
);
  localparam int LAST = TLC_TASKS - 1;

  logic [NUM_SRC-1:0] srcPrev;
  logic [NUM_SRC-1:0] srcFall;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) srcPrev <= '0;
    else       srcPrev <= srcLines;
  end
  assign srcFall = srcPrev & ~srcLines;

  logic [TLC_TASKS-1:0] setFlagV, setOvfV, bgHitV, finishV;

  generate
    for (genvar t = 0; t < TLC_TASKS; t++) begin : g_task
      logic [SEL_W-1:0] selV;
      logic hit, isBg, ackHit, trig, busy;
      assign selV = selFlat[t*SEL_W +: SEL_W];
      always_comb begin
        hit = 1'b0;
        for (int s = 0; s < NUM_SRC; s++)
          if (selV == SEL_W'(s + 1)) hit = srcFall[s];
      end
      assign isBg   = bgEnable && (t == LAST);
      assign ackHit = ackValid && ackEnable && (ackTask == TLC_IDX_W'(t));
      assign trig   = enableMask[t] &&
                      (isBg ? ((hit && bgTrigEn) || bgStartWr) : (hit || ackHit));
      assign busy   = runMask[t] || flagMask[t];
      assign setFlagV[t] = trig && !(isBg && busy);
      assign setOvfV[t]  = trig && !isBg && flagMask[t];
      assign bgHitV[t]   = trig && isBg && busy;
      assign finishV[t]  = doneValid && (doneTask == TLC_IDX_W'(t)) && runMask[t];
    end
  endgenerate

  logic [TLC_IDX_W-1:0] pick;
  logic found;
  always_comb begin
    pick  = '0;
    found = 1'b0;
    for (int t = TLC_TASKS - 1; t >= 0; t--)
      if (flagMask[t]) begin
        pick  = TLC_IDX_W'(t);
        found = 1'b1;
      end
  end

  always_comb begin
    stb.setFlag   = setFlagV;
    stb.setOvf    = setOvfV;
    stb.setBgOvf  = |bgHitV;
    stb.launch    = found && (runMask == '0);
    stb.launchIdx = pick;
    stb.finish    = finishV;
  end

  assert_lowest_first_R5: assert property (@(posedge clk) disable iff (!rstN)
    stb.launch |-> (flagMask[stb.launchIdx] &&
      ((flagMask & ((TLC_TASKS'(1) << stb.launchIdx) - TLC_TASKS'(1))) == '0)));
  assert_finish_running_R6: assert property (@(posedge clk) disable iff (!rstN)
    ((stb.finish & ~runMask) == '0));
endmodule

// File: rtl/tlc_regs.sv
module tlc_regs
  import tlc_pkg::*;
#(
  parameter int SEL_W = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       cfgWe,
  input  logic [TLC_ADDR_W-1:0]      cfgAddr,
  input  logic [TLC_TASKS-1:0]       cfgWdata,
  input  logic                       engUnderflow,
  input  strobe_t                    stb,
  output logic [TLC_TASKS*SEL_W-1:0] selFlat,
  output logic [TLC_TASKS-1:0]       enableMask,
  output logic                       ackEnable,
  output logic                       bgEnable,
  output logic                       bgTrigEn,
  output logic                       bgStartWr,
  output logic [TLC_TASKS-1:0]       flagMask,
  output logic [TLC_TASKS-1:0]       runMask,
  output logic [TLC_TASKS-1:0]       ovfMask,
  output logic                       bgOvf,
  output logic                       launchValid,
  output logic [TLC_IDX_W-1:0]       launchTask,
  output logic [TLC_TASKS-1:0]       doneIrq,
  output logic                       ovfIrq,
  output logic                       undIrq
);
  logic [SEL_W-1:0] selReg [TLC_TASKS];
  logic [TLC_TASKS-1:0] launchOh, ovfClr;
  logic bgClr;

  assign launchOh  = stb.launch ? (TLC_TASKS'(1) << stb.launchIdx) : '0;
  assign ovfClr    = (cfgWe && cfgAddr == TLC_ADDR_W'(A_OVF_CLR)) ? cfgWdata : '0;
  assign bgClr     = cfgWe && cfgAddr == TLC_ADDR_W'(A_BG_OVF_CLR) && cfgWdata[0];
  assign bgStartWr = cfgWe && cfgAddr == TLC_ADDR_W'(A_BG_START) && cfgWdata[0];

  generate
    for (genvar t = 0; t < TLC_TASKS; t++) begin : g_sel
      assign selFlat[t*SEL_W +: SEL_W] = selReg[t];
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int t = 0; t < TLC_TASKS; t++) selReg[t] <= '0;
      enableMask  <= '0;
      ackEnable   <= 1'b0;
      bgEnable    <= 1'b0;
      bgTrigEn    <= 1'b0;
      flagMask    <= '0;
      runMask     <= '0;
      ovfMask     <= '0;
      bgOvf       <= 1'b0;
      launchValid <= 1'b0;
      launchTask  <= '0;
      doneIrq     <= '0;
      ovfIrq      <= 1'b0;
      undIrq      <= 1'b0;
    end else begin
      for (int t = 0; t < TLC_TASKS; t++)
        if (cfgWe && cfgAddr == TLC_ADDR_W'(A_SEL_BASE + t))
          selReg[t] <= cfgWdata[SEL_W-1:0];
      if (cfgWe && cfgAddr == TLC_ADDR_W'(A_ENABLE)) enableMask <= cfgWdata;
      if (cfgWe && cfgAddr == TLC_ADDR_W'(A_CTRL)) begin
        ackEnable <= cfgWdata[0];
        bgEnable  <= cfgWdata[1];
        bgTrigEn  <= cfgWdata[2];
      end
      flagMask    <= (flagMask & ~launchOh) | stb.setFlag;
      runMask     <= (runMask & ~stb.finish) | launchOh;
      ovfMask     <= (ovfMask & ~ovfClr) | stb.setOvf;
      bgOvf       <= (bgOvf && !bgClr) || stb.setBgOvf;
      launchValid <= stb.launch;
      launchTask  <= stb.launchIdx;
      doneIrq     <= stb.finish;
      ovfIrq      <= (|stb.setOvf) || stb.setBgOvf;
      undIrq      <= engUnderflow;
    end
  end

  assert_run_onehot_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(runMask));
  assert_launch_idle_R5: assert property (@(posedge clk) disable iff (!rstN)
    launchValid |-> ($past(runMask) == '0 && runMask[launchTask]));
  assert_done_irq_R6: assert property (@(posedge clk) disable iff (!rstN)
    (doneIrq != '0) |-> (($past(runMask) & doneIrq) == doneIrq && (runMask & doneIrq) == '0));
  assert_no_silent_overflow_R7: assert property (@(posedge clk) disable iff (!rstN)
    ((ovfMask & ~$past(ovfMask)) != '0) |-> ovfIrq);
  assert_bg_overflow_irq_R9: assert property (@(posedge clk) disable iff (!rstN)
    (bgOvf && !$past(bgOvf)) |-> ovfIrq);
  assert_underflow_follow_R10: assert property (@(posedge clk) disable iff (!rstN)
    undIrq |-> $past(engUnderflow));
endmodule

// File: rtl/task_launch_ctrl.sv
module task_launch_ctrl
  import tlc_pkg::*;
#(
  parameter int NUM_SRC = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_SRC-1:0]    srcLines,
  input  logic                  cfgWe,
  input  logic [TLC_ADDR_W-1:0] cfgAddr,
  input  logic [TLC_TASKS-1:0]  cfgWdata,
  input  logic                  ackValid,
  input  logic [TLC_IDX_W-1:0]  ackTask,
  input  logic                  doneValid,
  input  logic [TLC_IDX_W-1:0]  doneTask,
  input  logic                  engUnderflow,
  output logic                  launchValid,
  output logic [TLC_IDX_W-1:0]  launchTask,
  output logic [TLC_TASKS-1:0]  runMask,
  output logic [TLC_TASKS-1:0]  flagMask,
  output logic [TLC_TASKS-1:0]  ovfMask,
  output logic                  bgOvf,
  output logic [TLC_TASKS-1:0]  doneIrq,
  output logic                  ovfIrq,
  output logic                  undIrq
);
  localparam int SEL_W = $clog2(NUM_SRC + 1);

  strobe_t stb;
  logic [TLC_TASKS*SEL_W-1:0] selFlat;
  logic [TLC_TASKS-1:0] enableMask;
  logic ackEnable, bgEnable, bgTrigEn, bgStartWr;

  tlc_trigger_ctl #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_ctl (
    .clk(clk), .rstN(rstN), .srcLines(srcLines), .selFlat(selFlat),
    .enableMask(enableMask), .flagMask(flagMask), .runMask(runMask),
    .ackEnable(ackEnable), .bgEnable(bgEnable), .bgTrigEn(bgTrigEn),
    .bgStartWr(bgStartWr), .ackValid(ackValid), .ackTask(ackTask),
    .doneValid(doneValid), .doneTask(doneTask), .stb(stb)
  );

  tlc_regs #(.SEL_W(SEL_W)) u_regs (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .engUnderflow(engUnderflow), .stb(stb), .selFlat(selFlat),
    .enableMask(enableMask), .ackEnable(ackEnable), .bgEnable(bgEnable),
    .bgTrigEn(bgTrigEn), .bgStartWr(bgStartWr), .flagMask(flagMask),
    .runMask(runMask), .ovfMask(ovfMask), .bgOvf(bgOvf),
    .launchValid(launchValid), .launchTask(launchTask), .doneIrq(doneIrq),
    .ovfIrq(ovfIrq), .undIrq(undIrq)
  );
endmodule

// File: tb/task_launch_ctrl_bench.sv
module task_launch_ctrl_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] srcLines = 8'hFF;
  logic cfgWe = 1'b0;
  logic [3:0] cfgAddr = '0;
  logic [7:0] cfgWdata = '0;
  logic ackValid = 1'b0;
  logic [2:0] ackTask = '0;
  logic doneValid = 1'b0;
  logic [2:0] doneTask = '0;
  logic engUnderflow = 1'b0;
  logic launchValid, bgOvf, ovfIrq, undIrq;
  logic [2:0] launchTask;
  logic [7:0] runMask, flagMask, ovfMask, doneIrq;

  task_launch_ctrl u_task_launch_ctrl (
    .clk(clk), .rstN(rstN), .srcLines(srcLines), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .cfgWdata(cfgWdata), .ackValid(ackValid), .ackTask(ackTask), .doneValid(doneValid),
    .doneTask(doneTask), .engUnderflow(engUnderflow), .launchValid(launchValid),
    .launchTask(launchTask), .runMask(runMask), .flagMask(flagMask), .ovfMask(ovfMask),
    .bgOvf(bgOvf), .doneIrq(doneIrq), .ovfIrq(ovfIrq), .undIrq(undIrq)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  string curReq = "R11";

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s during %s: actual=%0h expected=%0h", tag, curReq, act, exp);
    end
  endtask

  // Behavioural reference state
  logic [7:0] mEn, mFlag, mRun, mOvf, mDone, mPrev;
  logic mAckEn, mBgEn, mBgTrig, mBgOvf, mLaunchV, mOvfIrq, mUndIrq;
  logic [2:0] mLaunchT;
  int mSel [8];

  always @(posedge clk) begin : model
    logic [7:0] setF, setO;
    logic setB, edgeHit, trig, bgStart;
    int pick, s;
    if (!rstN) begin
      mEn = 0; mFlag = 0; mRun = 0; mOvf = 0; mDone = 0; mPrev = 0;
      mAckEn = 0; mBgEn = 0; mBgTrig = 0; mBgOvf = 0; mLaunchV = 0;
      mOvfIrq = 0; mUndIrq = 0; mLaunchT = 0;
      for (int t = 0; t < 8; t++) mSel[t] = 0;
    end else begin
      setF = 0; setO = 0; setB = 0;
      bgStart = cfgWe && cfgAddr == 4'd3 && cfgWdata[0];
      for (int t = 0; t < 8; t++) begin
        s = mSel[t];
        edgeHit = (s >= 1 && s <= 8) ? (mPrev[s-1] && !srcLines[s-1]) : 1'b0;
        if (mBgEn && t == 7) trig = (edgeHit && mBgTrig) || bgStart;
        else trig = edgeHit || (ackValid && mAckEn && ackTask == 3'(t));
        if (trig && mEn[t]) begin
          if (mBgEn && t == 7) begin
            if (mRun[7] || mFlag[7]) setB = 1; else setF[t] = 1;
          end else begin
            if (mFlag[t]) setO[t] = 1;
            setF[t] = 1;
          end
        end
      end
      pick = -1;
      if (mRun == 0)
        for (int t = 7; t >= 0; t--) if (mFlag[t]) pick = t;
      mDone = 0;
      if (doneValid && mRun[doneTask]) begin
        mDone[doneTask] = 1;
        mRun[doneTask] = 0;
      end
      mLaunchV = (pick >= 0);
      if (pick >= 0) begin
        mLaunchT = 3'(pick);
        mFlag[pick] = 0;
        mRun[pick] = 1;
      end
      mFlag = mFlag | setF;
      if (cfgWe && cfgAddr == 4'd1) mOvf = mOvf & ~cfgWdata;
      mOvf = mOvf | setO;
      if (cfgWe && cfgAddr == 4'd4 && cfgWdata[0]) mBgOvf = 0;
      if (setB) mBgOvf = 1;
      mOvfIrq = (setO != 0) || setB;
      mUndIrq = engUnderflow;
      if (cfgWe && cfgAddr == 4'd0) mEn = cfgWdata;
      if (cfgWe && cfgAddr == 4'd2) begin
        mAckEn = cfgWdata[0]; mBgEn = cfgWdata[1]; mBgTrig = cfgWdata[2];
      end
      if (cfgWe && cfgAddr >= 4'd8) mSel[int'(cfgAddr) - 8] = int'(cfgWdata[3:0]);
      mPrev = srcLines;
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      chk("R1 flagMask", flagMask, mFlag);
      chk("R5 runMask", runMask, mRun);
      chk("R5 launchValid", 8'(launchValid), 8'(mLaunchV));
      if (mLaunchV) chk("R5 launchTask", 8'(launchTask), 8'(mLaunchT));
      chk("R6 doneIrq", doneIrq, mDone);
      chk("R7 ovfMask", ovfMask, mOvf);
      chk("R7 ovfIrq", 8'(ovfIrq), 8'(mOvfIrq));
      chk("R9 bgOvf", 8'(bgOvf), 8'(mBgOvf));
      chk("R10 undIrq", 8'(undIrq), 8'(mUndIrq));
    end
  end

  task automatic step(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask
  task automatic wr(int a, int d);
    cfgWe = 1; cfgAddr = 4'(a); cfgWdata = 8'(d);
    step();
    cfgWe = 0;
  endtask
  task automatic ack(int t);
    ackValid = 1; ackTask = 3'(t);
    step();
    ackValid = 0;
  endtask
  task automatic done(int t);
    doneValid = 1; doneTask = 3'(t);
    step();
    doneValid = 0;
  endtask
  task automatic pulseLine(int i);
    srcLines[i] = 0;
    step();
    srcLines[i] = 1;
  endtask
  task automatic idleCheck(string tag);
    #1;
    chk(tag, runMask, 8'h00);
    chk(tag, flagMask, 8'h00);
    #0;
  endtask

  initial begin : watchdog
    while (cycles < 20000) begin
      @(posedge clk);
      cycles++;
    end
    fails++;
    checks++;
    $display("FAIL watchdog expired during %s: actual=%0d expected=<20000", curReq, cycles);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    step(4);
    rstN = 1;
    #1;
    chk("R11 reset runMask", runMask, 8'h00);
    chk("R11 reset flagMask", flagMask, 8'h00);
    chk("R11 reset ovfMask", ovfMask, 8'h00);
    chk("R11 reset irq", {4'h0, launchValid, bgOvf, ovfIrq, undIrq}, 8'h00);
    step();
    for (int t = 0; t < 8; t++) wr(8 + t, t + 1);

    curReq = "R2";
    srcLines[0] = 0; step(3);
    wr(0, 8'hFF); step(3);
    srcLines[0] = 1; step(3);
    idleCheck("R2 no late start");

    curReq = "R1";
    pulseLine(1); step(4);
    chk("R1 task1 running", runMask, 8'h02);
    done(1); step(2);

    curReq = "R3";
    wr(8 + 2, 0);
    pulseLine(2); step(4);
    idleCheck("R3 unselected");
    wr(8 + 3, 6);
    pulseLine(5); step(4);
    done(3); step(3);
    done(5); step(2);

    curReq = "R4";
    ack(4); step(3);
    idleCheck("R4 ack disabled");
    wr(2, 1);
    ack(4); step(3);
    done(4); step(2);

    curReq = "R5";
    ack(0); step(2);
    ack(6); ack(1); step(2);
    done(0); step(3);
    done(1); step(3);
    done(6); step(2);

    curReq = "R7";
    ack(0); step(2);
    ack(2); ack(2); step(2);
    chk("R7 overflow set", ovfMask, 8'h04);
    wr(1, 8'h04); step();
    done(0); step(3);
    done(2); step(2);
    done(5); step(2);

    curReq = "R8";
    wr(2, 3);
    ack(7); step(3);
    idleCheck("R8 ack ignored");
    curReq = "R9";
    pulseLine(7); step(3);
    idleCheck("R9 gate closed");
    curReq = "R8";
    wr(3, 1); step(2);
    chk("R8 bg running", runMask, 8'h80);
    curReq = "R9";
    wr(3, 1); step(2);
    chk("R9 bg overflow", 8'(bgOvf), 8'h01);
    wr(4, 1); step();
    done(7); step(2);
    wr(2, 7);
    pulseLine(7); step(3);
    done(7); step(2);

    curReq = "R10";
    engUnderflow = 1; step();
    engUnderflow = 0; step(3);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule